// File: doc/BRIEF.md
# Flash Protection Mode Controller

This block keeps the lifecycle protection level of an on-chip flash array and decides, access by access, whether a request may proceed. Three protection levels exist: an unrestricted level, a guarded level that locks the debug port out and can be left only after a full erase of the array, and a terminal level that locks out every debug access and every externally started erase for good. On top of the level, every flash row carries a read-protect bit and a write-protect bit that selectively block debug reads and writes of that row.

The level and the row bits sit in registers that stand in for nonvolatile storage. They are loaded from preset inputs while reset is held. Level changes arrive as requests with a target code. Erase completion arrives as a single-cycle event from the erase engine. Row bits are written one row at a time. Every access request carries a source (debug port, external programmer, internal firmware), an operation and a row. The block answers it combinationally in the same cycle with an allow or a deny. Illegal level changes and row-bit writes made outside the unrestricted level are refused. A refusal produces a one-cycle reject pulse and sets a sticky error flag.

Top module: `flash_guard_ctrl`

## Requirements
- R1: While rst_n is low, the level register loads boot_mode_i and the row bits load boot_rd_prot_i and boot_wr_prot_i. After reset, reject_o and error_o are 0.
- R2: Level codes are 00 = open, 01 = guarded and 11 = locked. From open, a request for 01 or 11 is accepted and mode_o shows the target on the cycle after the request. A request for the current level is accepted and changes nothing.
- R3: In the guarded level, every debug-port access (acc_src_i = 00) is denied. External-programmer erases (acc_src_i = 01, acc_op_i = 10) are allowed.
- R4: A request for 00 from the guarded level is accepted only if erase_done_i was seen in an earlier cycle while the level was guarded. Otherwise it is rejected. An erase pulse in the same cycle as the request does not qualify it. Entering the guarded level clears any earlier erase qualification.
- R5: In the locked level, every debug access and every external-programmer erase is denied. No request and no erase event ever moves the level out of locked.
- R6: A stored level code of 10 behaves as the locked level and is reported on mode_o as 11. A request whose target is 10 is always rejected.
- R7: In the open level, a debug read (acc_op_i = 00) of row n is allowed only if bit n of rd_prot_o is 0. A debug write (acc_op_i = 01) of row n is allowed only if bit n of wr_prot_o is 0. A debug erase (acc_op_i = 10) is allowed regardless of the row bits. Operation 11, external reads and external writes, and source 11 are always denied.
- R8: Firmware requests (acc_src_i = 10) are allowed for every operation, row and level.
- R9: A rejected request leaves all state unchanged. On the next cycle, reject_o is high for exactly one cycle, and error_o goes high and stays high until reset.
- R10: erase_done_i clears all row bits on the next cycle, and this takes priority over a row-bit write in the same cycle. A row-bit write is applied only in the open level. In any other level it is rejected as in R9.
- R11: While acc_req_i is high, exactly one of acc_allow_o and acc_deny_o is high in the same cycle. While acc_req_i is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the preset values |
| boot_mode_i | input | 2 | Preset protection level loaded during reset |
| boot_rd_prot_i | input | ROWS | Preset per-row read-protect bits |
| boot_wr_prot_i | input | ROWS | Preset per-row write-protect bits |
| mode_req_i | input | 1 | Level-change request strobe |
| mode_tgt_i | input | 2 | Requested level code |
| erase_done_i | input | 1 | One-cycle full-erase completion event |
| prot_wr_i | input | 1 | Row-bit write strobe |
| prot_row_i | input | ROW_AW | Row addressed by the row-bit write |
| prot_rd_val_i | input | 1 | New read-protect value for that row |
| prot_wr_val_i | input | 1 | New write-protect value for that row |
| acc_req_i | input | 1 | Access request valid |
| acc_src_i | input | 2 | Source: 00 debug, 01 external programmer, 10 firmware |
| acc_op_i | input | 2 | Operation: 00 read, 01 write, 10 erase |
| acc_row_i | input | ROW_AW | Row targeted by the access |
| acc_allow_o | output | 1 | Access permitted |
| acc_deny_o | output | 1 | Access refused |
| mode_o | output | 2 | Current effective level |
| reject_o | output | 1 | One-cycle pulse after a refused request |
| error_o | output | 1 | Sticky refusal flag |
| rd_prot_o | output | ROWS | Current read-protect bits |
| wr_prot_o | output | ROWS | Current write-protect bits |

## Verification
A wrong level register shows at once on mode_o and on the same-cycle allow/deny answer to a debug access. For that reason, the bench sweeps every source, operation and row in each level reachable from the preset. A stale or misplaced erase qualification stays hidden until a return-to-open request arrives. The bench therefore probes that request with no erase, with a same-cycle erase, with an erase seen before entry, and with an erase seen after entry. In each case the outcome is visible on the cycle after the request. Corrupted row bits show on rd_prot_o and wr_prot_o one cycle after the write or erase, and on the per-row answers to debug reads and writes.

// File: rtl/fg_pkg.sv
// Package: shared encodings for the flash protection controller.
// Assumes: level codes are fixed by the nonvolatile format; 10 is never
// produced by the controller and is read back as the locked level.
package fg_pkg;

    typedef enum logic [1:0] {
        LVL_OPEN   = 2'b00,
        LVL_GUARD  = 2'b01,
        LVL_RSVD   = 2'b10,
        LVL_LOCK   = 2'b11
    } fg_level_e;

    typedef enum logic [1:0] {
        SRC_DEBUG  = 2'b00,
        SRC_EXTPRG = 2'b01,
        SRC_FW     = 2'b10,
        SRC_NONE   = 2'b11
    } fg_src_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_ERASE = 2'b10,
        OP_RSVD  = 2'b11
    } fg_op_e;

    // Fail-safe decode: the unused code collapses onto the locked level.
    function automatic fg_level_e fg_decode(input logic [1:0] raw);
        fg_level_e lvl;
        case (raw)
            2'b00:   lvl = LVL_OPEN;
            2'b01:   lvl = LVL_GUARD;
            default: lvl = LVL_LOCK;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/fg_level_fsm.sv
// Module: fg_level_fsm
// Holds the lifecycle protection level and the erase qualification that
// permits leaving the guarded level. Judges each level-change request.
// Assumes: erase_done is a single-cycle event from the erase engine; the
// qualification it grants is registered, so a same-cycle request is not
// qualified by it.
module fg_level_fsm
    import fg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] boot_mode,
    input  logic       req_vld,
    input  logic [1:0] req_tgt,
    input  logic       erase_done,
    output fg_level_e  level,
    output logic       req_reject
);

    logic [1:0] mode_q;
    logic [1:0] mode_d;
    logic       erase_ok_q;
    logic       erase_ok_d;
    fg_level_e  cur;
    logic       legal;
    logic       moving;

    assign cur = fg_decode(mode_q);

    // Legality of the requested target against the current level.
    always_comb begin
        legal = 1'b0;
        case (cur)
            LVL_OPEN:  legal = (req_tgt != LVL_RSVD);
            LVL_GUARD: legal = (req_tgt == LVL_GUARD) ||
                               ((req_tgt == LVL_OPEN) && erase_ok_q);
            default:   legal = (req_tgt == LVL_LOCK);
        endcase
    end

    assign req_reject = req_vld && !legal;
    assign moving     = req_vld && legal && (req_tgt != cur);

    // Next level and next erase qualification.
    always_comb begin
        mode_d     = mode_q;
        erase_ok_d = erase_ok_q;
        if (moving) begin
            mode_d     = req_tgt;
            erase_ok_d = 1'b0;
        end else if (erase_done && (cur == LVL_GUARD)) begin
            erase_ok_d = 1'b1;
        end
    end

    // Level register standing in for the nonvolatile cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= boot_mode;
            erase_ok_q <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            erase_ok_q <= erase_ok_d;
        end
    end

    assign level = cur;

endmodule

// File: rtl/fg_row_bits.sv
// Module: fg_row_bits
// Per-row read-protect and write-protect bits. They are loaded from presets
// during reset, cleared by a full erase, and written one row at a time
// only while writes are permitted.
// Assumes: wr_permit reflects the current (pre-update) level.
module fg_row_bits #(
    parameter int ROWS   = 8,
    parameter int ROW_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROWS-1:0]   boot_rd,
    input  logic [ROWS-1:0]   boot_wr,
    input  logic              erase_done,
    input  logic              wr_vld,
    input  logic [ROW_AW-1:0] wr_row,
    input  logic              wr_rd_val,
    input  logic              wr_wr_val,
    input  logic              wr_permit,
    output logic [ROWS-1:0]   rd_bits,
    output logic [ROWS-1:0]   wr_bits,
    output logic              wr_reject
);

    logic wr_apply;

    assign wr_apply  = wr_vld && wr_permit;
    assign wr_reject = wr_vld && !wr_permit;

    for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
        logic hit;
        assign hit = wr_apply && (int'(wr_row) == gi);

        // One row's pair of bits: preset, erase clear, or row write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_bits[gi] <= boot_rd[gi];
                wr_bits[gi] <= boot_wr[gi];
            end else if (erase_done) begin
                rd_bits[gi] <= 1'b0;
                wr_bits[gi] <= 1'b0;
            end else if (hit) begin
                rd_bits[gi] <= wr_rd_val;
                wr_bits[gi] <= wr_wr_val;
            end
        end
    end

endmodule

// File: rtl/fg_access_gate.sv
// Module: fg_access_gate
// Combinational permit/deny decision for one access. Inputs are the level,
// the source, the operation, the row and the row bits.
// Assumes: rows at or beyond ROWS do not exist and are refused to the
// debug port; firmware is never refused.
module fg_access_gate
    import fg_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int ROW_AW = 3
) (
    input  fg_level_e         level,
    input  logic              vld,
    input  logic [1:0]        src,
    input  logic [1:0]        op,
    input  logic [ROW_AW-1:0] row,
    input  logic [ROWS-1:0]   rd_bits,
    input  logic [ROWS-1:0]   wr_bits,
    output logic              allow,
    output logic              deny
);

    logic row_ok;
    logic rd_blk;
    logic wr_blk;
    logic permit;

    assign row_ok = int'(row) < ROWS;

    // Row bit lookup with out-of-range rows treated as protected.
    always_comb begin
        rd_blk = 1'b1;
        wr_blk = 1'b1;
        for (int i = 0; i < ROWS; i++) begin
            if (int'(row) == i) begin
                rd_blk = rd_bits[i];
                wr_blk = wr_bits[i];
            end
        end
    end

    // Policy table by source, then level, then operation.
    always_comb begin
        permit = 1'b0;
        case (src)
            SRC_FW: permit = 1'b1;
            SRC_DEBUG: begin
                if (level == LVL_OPEN) begin
                    case (op)
                        OP_READ:  permit = row_ok && !rd_blk;
                        OP_WRITE: permit = row_ok && !wr_blk;
                        OP_ERASE: permit = 1'b1;
                        default:  permit = 1'b0;
                    endcase
                end
            end
            SRC_EXTPRG: permit = (op == OP_ERASE) && (level != LVL_LOCK);
            default:    permit = 1'b0;
        endcase
    end

    assign allow = vld && permit;
    assign deny  = vld && !permit;

endmodule

// File: rtl/flash_guard_ctrl.sv
// Module: flash_guard_ctrl (top)
// Flash protection mode controller: lifecycle level, per-row protect bits,
// access gating, and refusal reporting.
// Assumes: preset inputs are stable while rst_n is low; the access answer is
// combinational and must be sampled in the request cycle.
module flash_guard_ctrl
    import fg_pkg::*;
#(
    parameter  int ROWS   = 8,
    localparam int ROW_AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_mode_i,
    input  logic [ROWS-1:0]   boot_rd_prot_i,
    input  logic [ROWS-1:0]   boot_wr_prot_i,
    input  logic              mode_req_i,
    input  logic [1:0]        mode_tgt_i,
    input  logic              erase_done_i,
    input  logic              prot_wr_i,
    input  logic [ROW_AW-1:0] prot_row_i,
    input  logic              prot_rd_val_i,
    input  logic              prot_wr_val_i,
    input  logic              acc_req_i,
    input  logic [1:0]        acc_src_i,
    input  logic [1:0]        acc_op_i,
    input  logic [ROW_AW-1:0] acc_row_i,
    output logic              acc_allow_o,
    output logic              acc_deny_o,
    output logic [1:0]        mode_o,
    output logic              reject_o,
    output logic              error_o
    ,
    output logic [ROWS-1:0]   rd_prot_o,
    output logic [ROWS-1:0]   wr_prot_o
);

    fg_level_e level;
    logic      lvl_rej;
    logic      row_rej;
    logic      rej_q;
    logic      err_q;

    fg_level_fsm u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_mode  (boot_mode_i),
        .req_vld    (mode_req_i),
        .req_tgt    (mode_tgt_i),
        .erase_done (erase_done_i),
        .level      (level),
        .req_reject (lvl_rej)
    );

    fg_row_bits #(.ROWS(ROWS), .ROW_AW(ROW_AW)) u_rows (
        .clk        (clk),
        .rst_n      (rst_n),
        .boot_rd    (boot_rd_prot_i),
        .boot_wr    (boot_wr_prot_i),
        .erase_done (erase_done_i),
        .wr_vld     (prot_wr_i),
        .wr_row     (prot_row_i),
        .wr_rd_val  (prot_rd_val_i),
        .wr_wr_val  (prot_wr_val_i),
        .wr_permit  (level == LVL_OPEN),
        .rd_bits    (rd_prot_o),
        .wr_bits    (wr_prot_o),
        .wr_reject  (row_rej)
    );

    fg_access_gate #(.ROWS(ROWS), .ROW_AW(ROW_AW)) u_gate (
        .level   (level),
        .vld     (acc_req_i),
        .src     (acc_src_i),
        .op      (acc_op_i),
        .row     (acc_row_i),
        .rd_bits (rd_prot_o),
        .wr_bits (wr_prot_o),
        .allow   (acc_allow_o),
        .deny    (acc_deny_o)
    );

    // Refusal pulse and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rej_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            rej_q <= lvl_rej || row_rej;
            err_q <= err_q || lvl_rej || row_rej;
        end
    end

    assign mode_o   = level;
    assign reject_o = rej_q;
    assign error_o  = err_q;

endmodule

// File: rtl/fg_checker.sv
// Module: fg_checker
// Temporal properties of the protection controller, bound to the top.
// Assumes: preset inputs are held constant outside reset.
module fg_checker #(
    parameter int ROWS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_req_i,
    input logic [1:0]      acc_src_i,
    input logic [1:0]      acc_op_i,
    input logic            erase_done_i,
    input logic            acc_allow_o,
    input logic            acc_deny_o,
    input logic [1:0]      mode_o,
    input logic            reject_o,
    input logic            error_o,
    input logic [ROWS-1:0] rd_prot_o,
    input logic [ROWS-1:0] wr_prot_o
);

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'b11 |=> mode_o == 2'b11); // R5
    AST_LOCK_EXT_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b11 && acc_req_i && acc_src_i == 2'b01) |-> acc_deny_o); // R5
    AST_GUARD_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b01 && acc_req_i && acc_src_i == 2'b00) |-> acc_deny_o); // R3
    AST_GUARD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'b01 |=> (mode_o == 2'b01 || mode_o == 2'b00)); // R4
    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b10); // R6
    AST_FW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && acc_src_i == 2'b10) |-> acc_allow_o); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> error_o); // R9
    AST_REJ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> error_o); // R9
    AST_ERASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done_i |=> (rd_prot_o == '0 && wr_prot_o == '0)); // R10
    AST_ROWS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'b00 && !erase_done_i) |=> ($stable(rd_prot_o) && $stable(wr_prot_o))); // R10
    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req_i |-> (acc_allow_o ^ acc_deny_o)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_req_i |-> (!acc_allow_o && !acc_deny_o)); // R11
    AST_OPEN_DBG_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00 && acc_req_i && acc_src_i == 2'b00 && acc_op_i == 2'b10) |-> acc_allow_o); // R7

endmodule

bind flash_guard_ctrl fg_checker #(.ROWS(ROWS)) u_fg_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_req_i    (acc_req_i),
    .acc_src_i    (acc_src_i),
    .acc_op_i     (acc_op_i),
    .erase_done_i (erase_done_i),
    .acc_allow_o  (acc_allow_o),
    .acc_deny_o   (acc_deny_o),
    .mode_o       (mode_o),
    .reject_o     (reject_o),
    .error_o      (error_o),
    .rd_prot_o    (rd_prot_o),
    .wr_prot_o    (wr_prot_o)
);

// File: tb/sim_flash_guard_ctrl.sv
// Bench for flash_guard_ctrl: sweeps over levels, sources, operations, rows
// and request targets, plus directed erase and row-bit sequences.
module sim_flash_guard_ctrl;

    localparam int ROWS = 8;
    localparam int AW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      boot_mode = 2'b00;
    logic [ROWS-1:0] boot_rd = '0;
    logic [ROWS-1:0] boot_wr = '0;
    logic            mreq = 1'b0;
    logic [1:0]      mtgt = 2'b00;
    logic            ers = 1'b0;
    logic            pwr = 1'b0;
    logic [AW-1:0]   prow = '0;
    logic            prd = 1'b0;
    logic            pwv = 1'b0;
    logic            areq = 1'b0;
    logic [1:0]      asrc = 2'b00;
    logic [1:0]      aop = 2'b00;
    logic [AW-1:0]   arow = '0;
    logic            allow;
    logic            deny;
    logic [1:0]      mode;
    logic            rej;
    logic            err;
    logic [ROWS-1:0] rdp;
    logic [ROWS-1:0] wrp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    flash_guard_ctrl #(.ROWS(ROWS)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_mode_i(boot_mode),
        .boot_rd_prot_i(boot_rd), .boot_wr_prot_i(boot_wr),
        .mode_req_i(mreq), .mode_tgt_i(mtgt), .erase_done_i(ers),
        .prot_wr_i(pwr), .prot_row_i(prow), .prot_rd_val_i(prd),
        .prot_wr_val_i(pwv), .acc_req_i(areq), .acc_src_i(asrc),
        .acc_op_i(aop), .acc_row_i(arow), .acc_allow_o(allow),
        .acc_deny_o(deny), .mode_o(mode), .reject_o(rej), .error_o(err),
        .rd_prot_o(rdp), .wr_prot_o(wrp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] dec(input logic [1:0] m);
        return (m == 2'b10) ? 2'b11 : m;
    endfunction

    // Expected permit from R3, R5, R7, R8.
    function automatic logic exp_permit(input logic [1:0] m, input logic [1:0] s,
                                        input logic [1:0] o, input int r,
                                        input logic [ROWS-1:0] rb, input logic [ROWS-1:0] wb);
        if (s == 2'b10) return 1'b1;
        if (s == 2'b01) return (o == 2'b10) && (m != 2'b11);
        if (s == 2'b00 && m == 2'b00) begin
            if (o == 2'b00) return !rb[r];
            if (o == 2'b01) return !wb[r];
            if (o == 2'b10) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Expected legality from R2, R4, R5, R6 with erase qualification eq.
    function automatic logic exp_legal(input logic [1:0] m, input logic [1:0] t, input logic eq);
        if (t == 2'b10) return 1'b0;
        if (m == 2'b00) return 1'b1;
        if (m == 2'b01) return (t == 2'b01) || (t == 2'b00 && eq);
        return t == 2'b11;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] bm, input logic [ROWS-1:0] r, input logic [ROWS-1:0] w);
        @(negedge clk);
        rst_n = 1'b0; boot_mode = bm; boot_rd = r; boot_wr = w;
        mreq = 0; ers = 0; pwr = 0; areq = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic request(input logic [1:0] t);
        mreq = 1'b1; mtgt = t;
        step();
        mreq = 1'b0;
    endtask

    task automatic erase_pulse();
        ers = 1'b1;
        step();
        ers = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL WATCHDOG actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 and R6: reset loads each preset; code 10 reads as 11.
        for (int bm = 0; bm < 4; bm++) begin
            do_reset(2'(bm), 8'h5A, 8'hC3);
            chk("R1 mode", 32'(mode), 32'(dec(2'(bm))));
            chk("R1 rd bits", 32'(rdp), 32'h5A);
            chk("R1 wr bits", 32'(wrp), 32'hC3);
            chk("R1 reject", 32'(rej), 0);
            chk("R1 error", 32'(err), 0);
            chk("R6 reported code", 32'(mode == 2'b10), 0);
        end

        // R3 R5 R7 R8 R11: sweep level x source x op x row.
        for (int bm = 0; bm < 4; bm++) begin
            do_reset(2'(bm), 8'hA5, 8'h3C);
            areq = 1'b0;
            #1;
            chk("R11 idle allow", 32'(allow), 0);
            chk("R11 idle deny", 32'(deny), 0);
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 4; o++) begin
                    for (int r = 0; r < ROWS; r++) begin
                        logic e;
                        @(negedge clk);
                        areq = 1'b1; asrc = 2'(s); aop = 2'(o); arow = AW'(r);
                        #1;
                        e = exp_permit(dec(2'(bm)), 2'(s), 2'(o), r, 8'hA5, 8'h3C);
                        chk("R3/R5/R7/R8 allow", 32'(allow), 32'(e));
                        chk("R11 deny complement", 32'(deny), 32'(!e));
                    end
                end
            end
            @(negedge clk);
            areq = 1'b0;
        end

        // R2 R4 R5 R6 R9: every start level x every target, no erase.
        for (int bm = 0; bm < 4; bm++) begin
            for (int t = 0; t < 4; t++) begin
                logic lg;
                do_reset(2'(bm), '0, '0);
                lg = exp_legal(dec(2'(bm)), 2'(t), 1'b0);
                request(2'(t));
                chk("R2/R4/R5 mode after request", 32'(mode), 32'(lg ? 2'(t) : dec(2'(bm))));
                chk("R9 reject pulse", 32'(rej), 32'(!lg));
                chk("R9 error set", 32'(err), 32'(!lg));
                step();
                chk("R9 pulse one cycle", 32'(rej), 0);
                chk("R9 error sticky", 32'(err), 32'(!lg));
            end
        end

        // R4: erase seen while guarded qualifies a later return.
        do_reset(2'b01, '0, '0);
        erase_pulse();
        request(2'b00);
        chk("R4 return after erase", 32'(mode), 32'h0);
        chk("R4 no reject", 32'(rej), 0);

        // R4: same-cycle erase does not qualify.
        do_reset(2'b01, '0, '0);
        ers = 1'b1;
        request(2'b00);
        ers = 1'b0;
        chk("R4 same-cycle erase mode", 32'(mode), 32'h1);
        chk("R4 same-cycle erase reject", 32'(rej), 1);

        // R4: erase before entering guarded is forgotten.
        do_reset(2'b00, '0, '0);
        erase_pulse();
        request(2'b01);
        chk("R2 open to guarded", 32'(mode), 32'h1);
        request(2'b00);
        chk("R4 stale erase mode", 32'(mode), 32'h1);
        chk("R4 stale erase reject", 32'(rej), 1);
        // R9: error stays set through later legal activity.
        erase_pulse();
        request(2'b00);
        chk("R4 qualified after entry", 32'(mode), 32'h0);
        chk("R9 error still set", 32'(err), 1);

        // R5: locked survives erase and return request.
        do_reset(2'b00, '0, '0);
        request(2'b11);
        chk("R2 open to locked", 32'(mode), 32'h3);
        erase_pulse();
        request(2'b00);
        chk("R5 lock after erase", 32'(mode), 32'h3);
        chk("R5 lock reject", 32'(rej), 1);
        request(2'b01);
        chk("R5 lock to guarded refused", 32'(mode), 32'h3);

        // R10: row writes in open, refused elsewhere, erase clears.
        do_reset(2'b00, '0, '0);
        for (int r = 0; r < ROWS; r++) begin
            pwr = 1'b1; prow = AW'(r); prd = r[0]; pwv = r[1];
            step();
        end
        pwr = 1'b0;
        chk("R10 rd bits written", 32'(rdp), 32'hAA);
        chk("R10 wr bits written", 32'(wrp), 32'hCC);
        chk("R10 open write no reject", 32'(err), 0);
        // R7: the written bits gate debug reads per row.
        for (int r = 0; r < ROWS; r++) begin
            areq = 1'b1; asrc = 2'b00; aop = 2'b00; arow = AW'(r);
            #1;
            chk("R7 row read gate", 32'(allow), 32'(!r[0]));
            @(negedge clk);
        end
        areq = 1'b0;
        request(2'b01);
        pwr = 1'b1; prow = 3'd1; prd = 1'b0; pwv = 1'b0;
        step();
        pwr = 1'b0;
        chk("R10 guarded write ignored rd", 32'(rdp), 32'hAA);
        chk("R10 guarded write ignored wr", 32'(wrp), 32'hCC);
        chk("R10 guarded write reject", 32'(rej), 1);
        ers = 1'b1; pwr = 1'b1; prow = 3'd0; prd = 1'b1; pwv = 1'b1;
        step();
        ers = 1'b0; pwr = 1'b0;
        chk("R10 erase clears rd", 32'(rdp), 0);
        chk("R10 erase clears wr", 32'(wrp), 0);
        do_reset(2'b00, '0, '0);
        ers = 1'b1; pwr = 1'b1; prow = 3'd5; prd = 1'b1; pwv = 1'b1;
        step();
        ers = 1'b0; pwr = 1'b0;
        chk("R10 erase beats write", 32'(rdp | wrp), 0);
        chk("R10 no reject in open", 32'(rej), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule